// File: doc/BRIEF.md
# Two-Way Page Translation Cache

This block caches page translations for 4 KB pages. A request presents a 40-bit virtual page number, a 12-bit page offset, a user/supervisor flag and a read/write flag. One cycle later the block reports whether the translation was found. On a hit it returns the 32-bit physical address, made of the cached 20-bit physical page number followed by the offset, which is passed through unchanged. If the access breaks the page's protection, the block reports a fault instead of a hit.

There are 128 entries, arranged as 64 sets of two ways. Each set has one bit that records its least recently used way. Each entry holds a supervisor-only attribute, a read-only attribute, a guarded attribute, and referenced and changed bits that the block maintains itself.

A fill port loads a translation after a miss. An invalidate port drops the entry for one virtual page number. A flush input clears every entry. The page table walk is done outside the block and feeds the fill port.

Top module: `tlb_2way`

## Requirements
- R1: After reset, and after any cycle in which flush_i is high, every entry is invalid and every lookup misses.
- R2: A lookup accepted at a clock edge is reported at the next edge. res_valid_o is high for exactly that one cycle. On a hit, res_pa_o = {physical page number, lk_off_i}.
- R3: The set index is vpn[5:0] and the tag is vpn[39:6]. Two pages with equal index bits and different tags are held at the same time, one in each way.
- R4: A fill goes into the way whose valid tag already matches the page, if there is one. Otherwise it goes into an invalid way, way 0 before way 1. Otherwise it goes into the set's least recently used way.
- R5: A hit or a fill makes the way it used the most recently used way of its set. A miss, a fault or an invalidate leaves the replacement order unchanged.
- R6: A lookup with lk_user_i=1 to a supervisor-only page faults. So does a lookup with lk_write_i=1 to a read-only page. A fault gives res_fault_o=1 and res_hit_o=0. res_pa_o, res_rc_o and res_guard_o are zero unless res_hit_o=1. On a hit, res_guard_o shows the page's guarded attribute.
- R7: res_rc_o = {referenced, changed} as held before the access (bit 1 referenced, bit 0 changed). Every hit sets referenced. A write hit sets changed. A fill clears both bits. A fault changes neither bit.
- R8: inv_i clears the valid entry whose page matches inv_vpn_i, in whichever way holds it, and touches nothing else. If no entry matches, it has no effect.
- R9: Requests are served in the priority flush_i, inv_i, fill_i, lk_valid_i. A lower-priority request in the same cycle is dropped, and a dropped lookup produces no result (res_valid_o=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| inv_i | input | 1 | Invalidate one page |
| inv_vpn_i | input | 40 | Page to invalidate |
| fill_i | input | 1 | Write a translation |
| fill_vpn_i | input | 40 | Virtual page being filled |
| fill_ppn_i | input | 20 | Physical page for the fill |
| fill_sup_i | input | 1 | Page is supervisor-only |
| fill_ro_i | input | 1 | Page is read-only |
| fill_grd_i | input | 1 | Page is guarded |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | 40 | Virtual page to translate |
| lk_off_i | input | 12 | Page offset |
| lk_user_i | input | 1 | Access comes from user mode |
| lk_write_i | input | 1 | Access is a write |
| res_valid_o | output | 1 | Lookup result present |
| res_hit_o | output | 1 | Translation found and allowed |
| res_fault_o | output | 1 | Protection fault |
| res_pa_o | output | 32 | Physical address |
| res_rc_o | output | 2 | Referenced/changed bits before the access |
| res_guard_o | output | 1 | Page is guarded |

## Verification
Every result is due exactly one clock edge after the lookup is accepted. State changes from a fill, an invalidate, a flush or a hit become visible to a lookup accepted at the very next edge. The bench drives one request per cycle on the falling edge. It advances its reference model by that request before the rising edge, and compares all result ports on the following falling edge, so each comparison lines up with the single register stage. Directed sequences cover eviction order, protection faults, referenced/changed upkeep, invalidation and the priority of simultaneous requests. A random run over a few colliding pages follows.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VPN_W = 40;
  localparam int unsigned PPN_W = 20;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned SETS  = 64;

  typedef struct packed {
    logic sup;
    logic ro;
    logic grd;
    logic rf;
    logic ch;
  } attr_t;
endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int unsigned SETS  = 64,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned TAG_W = 34,
  parameter int unsigned PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [PPN_W-1:0] ppn_o,
  output attr_t            attr_o,
  input  logic             fill_i,
  input  logic             clr_i,
  input  logic             touch_i,
  input  logic             touch_wr_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  attr_t            wr_attr_i
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [PPN_W-1:0] ppn_q  [SETS];
  attr_t            attr_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (flush_i) vld_q <= '0;
    else if (clr_i)   vld_q[idx_i] <= 1'b0;
    else if (fill_i)  vld_q[idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[idx_i]  <= wr_tag_i;
      ppn_q[idx_i]  <= wr_ppn_i;
      attr_q[idx_i] <= wr_attr_i;
    end else if (touch_i) begin
      attr_q[idx_i].rf <= 1'b1;
      attr_q[idx_i].ch <= attr_q[idx_i].ch | touch_wr_i;
    end
  end

  assign vld_o  = vld_q[idx_i];
  assign tag_o  = tag_q[idx_i];
  assign ppn_o  = ppn_q[idx_i];
  assign attr_o = attr_q[idx_i];
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             we_i,
  input  logic             wd_i,
  output logic             lru_o
);
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lru_q <= '0;
    else if (we_i) lru_q[idx_i] <= wd_i;
  end

  assign lru_o = lru_q[idx_i];
endmodule

// File: rtl/tlb_2way.sv
module tlb_2way
  import tlb_pkg::*;
#(
  parameter int unsigned VPN_W = tlb_pkg::VPN_W,
  parameter int unsigned PPN_W = tlb_pkg::PPN_W,
  parameter int unsigned OFF_W = tlb_pkg::OFF_W,
  parameter int unsigned SETS  = tlb_pkg::SETS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             inv_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_sup_i,
  input  logic             fill_ro_i,
  input  logic             fill_grd_i,
  input  logic             lk_valid_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [OFF_W-1:0] lk_off_i,
  input  logic             lk_user_i,
  input  logic             lk_write_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic             res_fault_o,
  output logic [PPN_W+OFF_W-1:0] res_pa_o,
  output logic [1:0]       res_rc_o,
  output logic             res_guard_o
);
  localparam int unsigned WAYS  = 2;
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = VPN_W - IDX_W;
  localparam int unsigned PA_W  = PPN_W + OFF_W;

  logic do_flush, do_inv, do_fill, do_lk;
  logic [VPN_W-1:0] vpn_sel;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  assign do_flush = flush_i;
  assign do_inv   = !flush_i && inv_i;
  assign do_fill  = !flush_i && !inv_i && fill_i;
  assign do_lk    = !flush_i && !inv_i && !fill_i && lk_valid_i;

  always_comb begin
    if (do_inv)       vpn_sel = inv_vpn_i;
    else if (do_fill) vpn_sel = fill_vpn_i;
    else              vpn_sel = lk_vpn_i;
  end
  assign idx = vpn_sel[IDX_W-1:0];
  assign tag = vpn_sel[VPN_W-1:IDX_W];

  logic [WAYS-1:0]  vld, match, wr_en, clr_en, touch_en;
  logic [TAG_W-1:0] tag_rd [WAYS];
  logic [PPN_W-1:0] ppn_rd [WAYS];
  attr_t            attr_rd[WAYS];
  attr_t            fill_attr;
  logic             lru, victim, used_way, hit_way, any, fault, hit;
  attr_t            attr_h;
  logic [PPN_W-1:0] ppn_h;

  assign fill_attr = '{sup: fill_sup_i, ro: fill_ro_i, grd: fill_grd_i, rf: 1'b0, ch: 1'b0};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_way (
      .clk_i, .rst_ni,
      .flush_i   (do_flush),
      .idx_i     (idx),
      .vld_o     (vld[w]),
      .tag_o     (tag_rd[w]),
      .ppn_o     (ppn_rd[w]),
      .attr_o    (attr_rd[w]),
      .fill_i    (wr_en[w]),
      .clr_i     (clr_en[w]),
      .touch_i   (touch_en[w]),
      .touch_wr_i(lk_write_i),
      .wr_tag_i  (tag),
      .wr_ppn_i  (fill_ppn_i),
      .wr_attr_i (fill_attr)
    );
    assign match[w]    = vld[w] && (tag_rd[w] == tag);
    assign wr_en[w]    = do_fill && (victim == w[0]);
    assign clr_en[w]   = do_inv && match[w];
    assign touch_en[w] = do_lk && hit && match[w];
  end

  assign any     = |match;
  assign hit_way = match[1];
  assign attr_h  = attr_rd[hit_way];
  assign ppn_h   = ppn_rd[hit_way];
  assign fault   = any && ((lk_user_i && attr_h.sup) || (lk_write_i && attr_h.ro));
  assign hit     = any && !fault;

  // victim: matching tag, then invalid way, then LRU way
  always_comb begin
    if (any)          victim = hit_way;
    else if (!vld[0]) victim = 1'b0;
    else if (!vld[1]) victim = 1'b1;
    else              victim = lru;
  end
  assign used_way = do_fill ? victim : hit_way;

  tlb_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk_i, .rst_ni,
    .idx_i (idx),
    .we_i  (do_fill || (do_lk && hit)),
    .wd_i  (!used_way),
    .lru_o (lru)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_fault_o <= 1'b0;
      res_pa_o    <= '0;
      res_rc_o    <= '0;
      res_guard_o <= 1'b0;
    end else begin
      res_valid_o <= do_lk;
      res_hit_o   <= do_lk && hit;
      res_fault_o <= do_lk && fault;
      res_pa_o    <= (do_lk && hit) ? {ppn_h, lk_off_i} : '0;
      res_rc_o    <= (do_lk && hit) ? {attr_h.rf, attr_h.ch} : 2'b00;
      res_guard_o <= do_lk && hit && attr_h.grd;
    end
  end
endmodule

// File: rtl/tlb_2way_sva.sv
module tlb_2way_sva #(
  parameter int unsigned VPN_W = 40,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned OFF_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             inv_i,
  input logic [VPN_W-1:0] inv_vpn_i,
  input logic             fill_i,
  input logic [VPN_W-1:0] fill_vpn_i,
  input logic [PPN_W-1:0] fill_ppn_i,
  input logic             fill_sup_i,
  input logic             fill_ro_i,
  input logic             fill_grd_i,
  input logic             lk_valid_i,
  input logic [VPN_W-1:0] lk_vpn_i,
  input logic [OFF_W-1:0] lk_off_i,
  input logic             lk_user_i,
  input logic             lk_write_i,
  input logic             res_valid_o,
  input logic             res_hit_o,
  input logic             res_fault_o,
  input logic [PPN_W+OFF_W-1:0] res_pa_o,
  input logic [1:0]       res_rc_o,
  input logic             res_guard_o
);
  p_result_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !flush_i && !inv_i && !fill_i) |=> res_valid_o);

  p_offset_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !flush_i && !inv_i && !fill_i) |=> (!res_hit_o || res_pa_o[OFF_W-1:0] == $past(lk_off_i)));

  p_dropped_lookup_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i || inv_i || fill_i) |=> !res_valid_o);

  p_flush_no_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !res_hit_o);

  p_hit_fault_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_hit_o && res_fault_o));

  p_quiet_unless_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_hit_o |-> (res_pa_o == '0 && res_rc_o == 2'b00 && !res_guard_o));

  p_flags_need_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!res_hit_o && !res_fault_o));
endmodule

bind tlb_2way tlb_2way_sva #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_sva (.*);

// File: tb/tb_tlb_2way.sv
`timescale 1ns/1ps
module tb_tlb_2way;
  localparam int VW = 40, PW = 20, OW = 12, NS = 64;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic flush_i = 0, inv_i = 0, fill_i = 0, lk_valid_i = 0;
  logic [VW-1:0] inv_vpn_i = '0, fill_vpn_i = '0, lk_vpn_i = '0;
  logic [PW-1:0] fill_ppn_i = '0;
  logic fill_sup_i = 0, fill_ro_i = 0, fill_grd_i = 0;
  logic [OW-1:0] lk_off_i = '0;
  logic lk_user_i = 0, lk_write_i = 0;
  logic res_valid_o, res_hit_o, res_fault_o, res_guard_o;
  logic [PW+OW-1:0] res_pa_o;
  logic [1:0] res_rc_o;

  always #2.5 clk = ~clk;

  tlb_2way dut (.clk_i(clk), .*);

  // reference model
  bit m_v[2][NS], m_sup[2][NS], m_ro[2][NS], m_grd[2][NS], m_rf[2][NS], m_ch[2][NS];
  logic [VW-7:0] m_tag[2][NS];
  logic [PW-1:0] m_ppn[2][NS];
  bit m_lru[NS];
  bit e_valid, e_hit, e_fault, e_guard;
  logic [PW+OW-1:0] e_pa;
  logic [1:0] e_rc;

  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R1";

  function automatic int find(logic [VW-1:0] v);
    int s = int'(v[5:0]);
    for (int w = 0; w < 2; w++)
      if (m_v[w][s] && m_tag[w][s] == v[VW-1:6]) return w;
    return -1;
  endfunction

  task automatic model_step();
    int s, w, vic;
    e_valid = 0; e_hit = 0; e_fault = 0; e_guard = 0; e_pa = '0; e_rc = 2'b00;
    if (flush_i) begin
      for (int a = 0; a < 2; a++) for (int b = 0; b < NS; b++) m_v[a][b] = 0;
    end else if (inv_i) begin
      w = find(inv_vpn_i);
      if (w >= 0) m_v[w][int'(inv_vpn_i[5:0])] = 0;
    end else if (fill_i) begin
      s = int'(fill_vpn_i[5:0]);
      w = find(fill_vpn_i);
      if (w >= 0) vic = w;
      else if (!m_v[0][s]) vic = 0;
      else if (!m_v[1][s]) vic = 1;
      else vic = int'(m_lru[s]);
      m_v[vic][s] = 1; m_tag[vic][s] = fill_vpn_i[VW-1:6]; m_ppn[vic][s] = fill_ppn_i;
      m_sup[vic][s] = fill_sup_i; m_ro[vic][s] = fill_ro_i; m_grd[vic][s] = fill_grd_i;
      m_rf[vic][s] = 0; m_ch[vic][s] = 0;
      m_lru[s] = (vic == 0);
    end else if (lk_valid_i) begin
      e_valid = 1;
      s = int'(lk_vpn_i[5:0]);
      w = find(lk_vpn_i);
      if (w >= 0) begin
        if ((lk_user_i && m_sup[w][s]) || (lk_write_i && m_ro[w][s])) e_fault = 1;
        else begin
          e_hit = 1; e_pa = {m_ppn[w][s], lk_off_i};
          e_rc = {m_rf[w][s], m_ch[w][s]}; e_guard = m_grd[w][s];
          m_rf[w][s] = 1; if (lk_write_i) m_ch[w][s] = 1;
          m_lru[s] = (w == 0);
        end
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (res_valid_o !== e_valid || res_hit_o !== e_hit || res_fault_o !== e_fault ||
        res_pa_o !== e_pa || res_rc_o !== e_rc || res_guard_o !== e_guard) begin
      errors++;
      $display("FAIL %s t=%0t actual v%b h%b f%b pa%h rc%b g%b expected v%b h%b f%b pa%h rc%b g%b",
               req, $time, res_valid_o, res_hit_o, res_fault_o, res_pa_o, res_rc_o, res_guard_o,
               e_valid, e_hit, e_fault, e_pa, e_rc, e_guard);
    end
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    flush_i = 0; inv_i = 0; fill_i = 0; lk_valid_i = 0;
  endtask

  task automatic do_fill(logic [VW-1:0] v, logic [PW-1:0] p, bit sup = 0, bit ro = 0, bit grd = 0);
    fill_i = 1; fill_vpn_i = v; fill_ppn_i = p; fill_sup_i = sup; fill_ro_i = ro; fill_grd_i = grd;
    cyc();
  endtask

  task automatic look(logic [VW-1:0] v, bit usr = 0, bit wr = 0, logic [OW-1:0] off = 12'h5a3);
    lk_valid_i = 1; lk_vpn_i = v; lk_user_i = usr; lk_write_i = wr; lk_off_i = off;
    cyc();
  endtask

  task automatic invd(logic [VW-1:0] v);
    inv_i = 1; inv_vpn_i = v; cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired actual hung expected finished");
    finish_run();
  end

  localparam logic [VW-1:0] A = {34'h1, 6'd3}, B = {34'h2, 6'd3}, C = {34'h3, 6'd3};
  localparam logic [VW-1:0] D = {34'h7, 6'd10}, E = {34'h8, 6'd11}, F = {34'h9, 6'd12};

  initial begin
    repeat (3) @(negedge clk);
    req = "R1"; compare();
    rst_ni = 1;
    req = "R1"; look(A); look(B);
    req = "R2"; do_fill(A, 20'hAAAA1); look(A, 0, 0, 12'h123);
    req = "R7"; look(A, 0, 1); look(A); look(A);
    req = "R3"; do_fill(B, 20'hBBBB2); look(B); look(A);
    req = "R5"; look(B); look(A);                  // B now least recent
    req = "R4"; do_fill(C, 20'hCCCC3); look(B); look(A); look(C);
    req = "R4"; do_fill(A, 20'h11111); look(A); look(C);
    req = "R5"; look(F); do_fill(F, 20'h0F0F0);
    req = "R6"; do_fill(D, 20'hDDDD4, 1, 0, 1); look(D, 1, 0); look(D, 1, 1); look(D, 0, 0);
    req = "R6"; do_fill(E, 20'hEEEE5, 0, 1, 0); look(E, 0, 1); look(E, 1, 1);
    req = "R7"; look(E, 1, 0); look(E, 1, 0);
    req = "R8"; invd(C); look(C); look(A); invd({34'h55, 6'd3}); look(A);
    req = "R9"; fill_i = 1; fill_vpn_i = C; fill_ppn_i = 20'h33333; fill_sup_i = 0; fill_ro_i = 0;
    fill_grd_i = 0; lk_valid_i = 1; lk_vpn_i = A; cyc(); look(C);
    req = "R9"; inv_i = 1; inv_vpn_i = A; fill_i = 1; fill_vpn_i = B; cyc(); look(A); look(B);
    req = "R9"; flush_i = 1; inv_i = 1; inv_vpn_i = C; lk_valid_i = 1; lk_vpn_i = C; cyc();
    req = "R1"; look(C); look(D); look(E);
    req = "R4";
    for (int i = 0; i < 400; i++) begin
      logic [VW-1:0] v;
      int op;
      v = {34'(($urandom % 3) + 1), 6'(($urandom % 2) + 20)};
      op = int'($urandom % 10);
      if (op < 3)       do_fill(v, 20'($urandom), bit'($urandom), bit'($urandom), bit'($urandom));
      else if (op == 3) invd(v);
      else if (op == 4 && ($urandom % 8) == 0) begin flush_i = 1; cyc(); end
      else              look(v, bit'($urandom), bit'($urandom), 12'($urandom));
    end
    finish_run();
  end
endmodule